// File: doc/BRIEF.md
# Transmit Descriptor Chain Walker

This block moves frames out of memory by following a chain of four-word transmit descriptors. Software builds the chain in memory, sets the transmit-enable bit and writes the poll-demand register. The walker then reads each descriptor in turn. While a descriptor is owned by hardware, the walker fetches the frame bytes from its buffer and sends them on a valid/ready byte stream. It then writes the status back, hands the descriptor back to software, and follows the descriptor's next pointer.

The walk ends cleanly when the walker meets a descriptor that software owns. It raises a descriptor-unavailable event and keeps that descriptor's address, so a later poll continues from there. A memory error response stops the walker until a soft reset. The block does nothing on the line side: no CRC, no padding, no collision handling.

Top module: `tx_desc_walker`

## Requirements
- R1: After reset the register port reads as follows: control (offset 0) is 0, list base (offset 1) is 0xFFFFFFFC, status (offset 3) is 0 and current descriptor (offset 4) is 0. `tx_irq` is low and no memory request is made.
- R2: A write to the poll register (offset 2) is ignored while transmit-enable (control bit 8) is 0. No memory request follows and the current-descriptor register is unchanged.
- R3: The first poll after a reset or soft reset loads the current-descriptor register from the list base. Writes to the list base are ignored from that point until the next soft reset.
- R4: A descriptor holds four words at byte offsets 0 (flags), 4 (buffer address), 8 (status/length) and 12 (next pointer). Flags bit 31 set means hardware owns it. The frame is the low-16-bit length count of bytes, read from the buffer address at any byte alignment, with the lowest byte address of each word first. `fo_last` marks the final byte.
- R5: After the last byte, the walker writes the status/length word back with the length kept, bit 19 set, and bit 16 set when flags bit 2 was set. It then writes the flags word back with bit 31 cleared.
- R6: Each completed frame sets status bits 18 and 16. Writing a 1 to a status bit clears it. `tx_irq` is high while any status bit is set.
- R7: After a frame the walker fetches the descriptor at the next pointer. When it finds flags bit 31 clear, it sets status bit 23, stops, and leaves the current-descriptor register at that descriptor.
- R8: A poll after such a stop fetches the same descriptor again, with no step past it.
- R9: An error response on any memory access sets status bit 24 and halts the walker. Polls are then ignored until a soft reset (control bit 24 written as 1), which restores every register to its R1 value.
- R10: A descriptor with length 0 sends no bytes and is still written back and handed to software.
- R11: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ack`. `fo_valid`, `fo_data` and `fo_last` hold steady until `fo_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with ack |
| mem_ack | input | 1 | Memory access done |
| mem_err | input | 1 | Memory access failed, valid with ack |
| fo_valid | output | 1 | Frame byte valid |
| fo_data | output | 8 | Frame byte |
| fo_last | output | 1 | Final byte of frame |
| fo_ready | input | 1 | Sink accepts byte |
| tx_irq | output | 1 | Any status bit set |

## Verification
The assertions assume the memory side gives at most one `mem_ack` per request, and only while `mem_req` is high. They also assume no soft reset is written while a request or a byte is pending. The bench memory model acks only requests that are still open and waits a varying 0 to 2 cycles before each ack. The byte sink stalls in a fixed pattern. Soft resets are issued only after the walker has stopped.

// File: rtl/tx_desc_walker.sv
module tx_desc_walker #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  output logic          fo_valid,
  output logic [7:0]    fo_data,
  output logic          fo_last,
  input  logic          fo_ready,
  output logic          tx_irq
);
  localparam logic [AW-1:0] BASE_RST = {{(AW-2){1'b1}}, 2'b00};

  typedef enum logic [3:0] {
    S_IDLE, S_FLAGS, S_BUF, S_LEN, S_NEXT, S_DATA, S_SEND, S_WSTAT, S_WFLAGS, S_HALT
  } st_t;

  st_t           state;
  logic          en, started;
  logic [AW-1:0] base, cur, bufp, nxt;
  logic [15:0]   len, rem, shi;
  logic [30:0]   flg;
  logic [31:0]   word;
  logic          st_berr, st_tdu, st_cp, st_int;

  wire swr  = reg_wr && reg_addr == 3'd0 && reg_wdata[24];
  wire poll = reg_wr && reg_addr == 3'd2;
  wire clr  = reg_wr && reg_addr == 3'd3;

  assign mem_req  = state inside {S_FLAGS, S_BUF, S_LEN, S_NEXT, S_DATA, S_WSTAT, S_WFLAGS};
  assign mem_we   = state inside {S_WSTAT, S_WFLAGS};
  assign fo_valid = state == S_SEND;
  assign fo_data  = word[{bufp[1:0], 3'b000} +: 8];
  assign fo_last  = rem == 16'd1;
  assign tx_irq   = st_berr | st_tdu | st_cp | st_int;

  always_comb begin
    case (state)
      S_BUF:          mem_addr = cur + AW'(4);
      S_LEN, S_WSTAT: mem_addr = cur + AW'(8);
      S_NEXT:         mem_addr = cur + AW'(12);
      S_DATA:         mem_addr = {bufp[AW-1:2], 2'b00};
      default:        mem_addr = cur;
    endcase
    if (state == S_WSTAT) mem_wdata = {shi | 16'h0008 | {15'd0, flg[2]}, len};
    else                  mem_wdata = {1'b0, flg};
    case (reg_addr)
      3'd0:    reg_rdata = {23'd0, en, 8'd0};
      3'd1:    reg_rdata = 32'(base);
      3'd3:    reg_rdata = {7'd0, st_berr, st_tdu, 4'd0, st_cp, 1'b0, st_int, 16'd0};
      3'd4:    reg_rdata = 32'(cur);
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || swr) begin
      state <= S_IDLE; en <= 1'b0; started <= 1'b0;
      base <= BASE_RST; cur <= '0; bufp <= '0; nxt <= '0;
      len <= '0; rem <= '0; shi <= '0; flg <= '0; word <= '0;
      st_berr <= 1'b0; st_tdu <= 1'b0; st_cp <= 1'b0; st_int <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == 3'd0) en <= reg_wdata[8];
      if (reg_wr && reg_addr == 3'd1 && !started) base <= reg_wdata[AW-1:0];
      if (clr) begin
        if (reg_wdata[24]) st_berr <= 1'b0;
        if (reg_wdata[23]) st_tdu  <= 1'b0;
        if (reg_wdata[18]) st_cp   <= 1'b0;
        if (reg_wdata[16]) st_int  <= 1'b0;
      end
      case (state)
        S_IDLE:
          if (poll && en) begin
            started <= 1'b1;
            if (!started) cur <= base;
            state <= S_FLAGS;
          end
        S_SEND:
          if (fo_ready) begin
            bufp <= bufp + AW'(1);
            rem  <= rem - 16'd1;
            if (rem == 16'd1)          state <= S_WSTAT;
            else if (bufp[1:0] == 2'd3) state <= S_DATA;
          end
        S_HALT: state <= S_HALT;
        default:
          if (mem_ack) begin
            if (mem_err) begin
              st_berr <= 1'b1;
              state   <= S_HALT;
            end else begin
              case (state)
                S_FLAGS:
                  if (!mem_rdata[31]) begin
                    st_tdu <= 1'b1;
                    state  <= S_IDLE;
                  end else begin
                    flg   <= mem_rdata[30:0];
                    state <= S_BUF;
                  end
                S_BUF: begin bufp <= mem_rdata[AW-1:0]; state <= S_LEN; end
                S_LEN: begin
                  len <= mem_rdata[15:0]; rem <= mem_rdata[15:0]; shi <= mem_rdata[31:16];
                  state <= S_NEXT;
                end
                S_NEXT: begin
                  nxt   <= mem_rdata[AW-1:0];
                  state <= (len == 16'd0) ? S_WSTAT : S_DATA;
                end
                S_DATA:  begin word <= mem_rdata; state <= S_SEND; end
                S_WSTAT: state <= S_WFLAGS;
                S_WFLAGS: begin
                  st_cp  <= 1'b1;
                  st_int <= 1'b1;
                  cur    <= nxt;
                  state  <= S_FLAGS;
                end
                default: state <= S_IDLE;
              endcase
            end
          end
      endcase
    end
  end

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !swr |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R11
  fo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fo_valid && !fo_ready && !swr |=> fo_valid && $stable(fo_data) && $stable(fo_last));

  // R4
  last_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fo_valid && fo_ready && fo_last && !swr |=> !fo_valid);

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_berr && !swr |=> !mem_req && !fo_valid);

  // R7
  stop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_tdu) |-> !mem_req && $stable(cur));
endmodule

// File: tb/tx_desc_walker_bench.sv
module tx_desc_walker_bench;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        mem_req, mem_we, mem_ack = 0, mem_err = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic        fo_valid, fo_last, fo_ready = 0, tx_irq;
  logic [7:0]  fo_data;

  always #4 clk = ~clk;

  tx_desc_walker #(.AW(32)) u_tx_desc_walker (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .fo_valid(fo_valid), .fo_data(fo_data), .fo_last(fo_last),
    .fo_ready(fo_ready), .tx_irq(tx_irq));

  int tests = 0, fails = 0, req_cnt = 0;
  bit done = 0, stall = 0;
  logic [31:0] mem [256];
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [8:0]  expq [$];
  int wcnt = 0, latsel = 0, rcnt = 0;

  function automatic logic [7:0] pat(input logic [31:0] a);
    return 8'(a * 7 + 3);
  endfunction

  always @(posedge clk) begin
    mem_ack <= 0; mem_err <= 0;
    if (mem_req && !mem_ack) begin
      if (wcnt == 0) begin
        mem_ack <= 1;
        if (mem_addr == err_addr) mem_err <= 1;
        else if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        else mem_rdata <= mem[mem_addr[9:2]];
        wcnt <= latsel;
        latsel <= (latsel == 2) ? 0 : latsel + 1;
      end else wcnt <= wcnt - 1;
    end
  end

  always @(posedge clk) begin
    rcnt <= rcnt + 1;
    fo_ready <= stall ? (rcnt % 4 != 1) : 1'b1;
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mem_req) req_cnt++;
    if (rst_n && fo_valid && fo_ready) begin
      if (expq.size() == 0) chk("R4 unexpected byte", {23'd0, fo_last, fo_data}, 32'h1FF);
      else chk("R4 frame byte", {23'd0, fo_last, fo_data}, {23'd0, expq.pop_front()});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic put_desc(input logic [31:0] at, input logic [31:0] f,
                          input logic [31:0] b, input logic [15:0] l, input logic [31:0] n);
    mem[at[9:2]] = f; mem[at[9:2]+1] = b; mem[at[9:2]+2] = {16'd0, l}; mem[at[9:2]+3] = n;
    for (int k = 0; k < l; k++) expq.push_back({k == l - 1, pat(b + k)});
  endtask

  task automatic wait_stop();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(3, s);
      if (s[23] || s[24]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    int rq;
    for (int i = 0; i < 256; i++)
      mem[i] = (i < 64) ? 32'd0 : {pat(i*4+3), pat(i*4+2), pat(i*4+1), pat(i*4)};
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 base", v, 32'hFFFF_FFFC);
    rd(3, v); chk("R1 status", v, 0);
    rd(4, v); chk("R1 cur", v, 0);
    chk("R1 irq", {31'd0, tx_irq}, 0);
    chk("R1 no req", req_cnt, 0);
    // R2 poll with enable clear
    wr(2, 1); repeat (20) @(negedge clk);
    chk("R2 no req", req_cnt, 0);
    rd(4, v); chk("R2 cur", v, 0);
    // R3/R4/R5/R7 walk of two frames
    wr(1, 32'h100);
    put_desc(32'h100, 32'h8000_0000, 32'h201, 5, 32'h110);
    put_desc(32'h110, 32'h8000_0004, 32'h240, 17, 32'h120);
    mem[32'h120 >> 2] = 0;
    stall = 1;
    wr(0, 32'h100); wr(2, 0);
    wait_stop();
    chk("R4 all bytes sent", expq.size(), 0);
    chk("R5 stat d0", mem[32'h108 >> 2], 32'h0008_0005);
    chk("R5 stat d1", mem[32'h118 >> 2], 32'h0009_0011);
    chk("R5 flags d0", mem[32'h100 >> 2], 32'h0);
    chk("R5 flags d1", mem[32'h110 >> 2], 32'h4);
    rd(3, v); chk("R6 R7 status", v, 32'h0085_0000);
    rd(4, v); chk("R7 cur at stop", v, 32'h120);
    chk("R6 irq", {31'd0, tx_irq}, 1);
    wr(1, 32'h300); rd(1, v); chk("R3 base locked", v, 32'h100);
    // R6 write one to clear
    wr(3, 32'h0001_0000); rd(3, v); chk("R6 w1c partial", v, 32'h0084_0000);
    wr(3, 32'hFFFF_FFFF); rd(3, v); chk("R6 w1c all", v, 0);
    chk("R6 irq low", {31'd0, tx_irq}, 0);
    // R8 refetch the same descriptor
    wr(2, 0); wait_stop();
    rd(4, v); chk("R8 still waiting", v, 32'h120);
    rd(3, v); chk("R8 tdu again", v, 32'h0080_0000);
    wr(3, 32'hFFFF_FFFF);
    put_desc(32'h120, 32'h8000_0000, 32'h283, 3, 32'h130);
    mem[32'h130 >> 2] = 0;
    wr(2, 0); wait_stop();
    chk("R8 bytes sent", expq.size(), 0);
    rd(4, v); chk("R8 cur advanced", v, 32'h130);
    rd(3, v); chk("R8 status", v, 32'h0085_0000);
    // R10 zero-length frame
    wr(3, 32'hFFFF_FFFF);
    put_desc(32'h130, 32'h8000_0004, 32'h2A0, 0, 32'h140);
    mem[32'h140 >> 2] = 0;
    wr(2, 0); wait_stop();
    chk("R10 stat word", mem[32'h138 >> 2], 32'h0009_0000);
    chk("R10 flags", mem[32'h130 >> 2], 32'h4);
    rd(4, v); chk("R10 cur", v, 32'h140);
    rd(3, v); chk("R10 status", v, 32'h0085_0000);
    // R9 bus error on data fetch
    wr(3, 32'hFFFF_FFFF);
    mem[32'h140 >> 2] = 32'h8000_0000; mem[32'h144 >> 2] = 32'h2C0;
    mem[32'h148 >> 2] = 4; mem[32'h14C >> 2] = 32'h150;
    err_addr = 32'h2C0;
    wr(2, 0); wait_stop();
    rd(3, v); chk("R9 berr", v, 32'h0100_0000);
    rq = req_cnt; wr(2, 0); repeat (20) @(negedge clk);
    chk("R9 poll ignored", req_cnt - rq, 0);
    chk("R9 no bytes", expq.size(), 0);
    err_addr = 32'hFFFF_FFFF;
    wr(0, 32'h0100_0000);
    rd(0, v); chk("R9 ctrl after swr", v, 0);
    rd(3, v); chk("R9 status after swr", v, 0);
    rd(4, v); chk("R9 cur after swr", v, 0);
    rd(1, v); chk("R9 base after swr", v, 32'hFFFF_FFFC);
    wr(1, 32'h180); rd(1, v); chk("R3 base writable after swr", v, 32'h180);
    // R11 handshakes observed under stall; final idle
    chk("R11 no pending byte", {31'd0, fo_valid}, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule